// File: doc/BRIEF.md
# Parallel Code-Store Programming Controller

This block is the device-side engine that a parallel programmer talks to when it loads the on-chip code store. It samples a small set of strap levels and four mode-select pins, which together pick one operation. It then works on a 12-bit address and an 8-bit data bus. The supported operations are: a self-timed byte write, a timed chip erase, three lock-bit writes, code read-back and a fixed identification (signature) read.

While an operation is running, the block holds a ready line low. During a byte write, a read of the address being written returns polling status on the top data bit, so the programmer can follow progress without watching the ready line. Three lock bits give increasing protection. The first stops code writes. The second also hides code read-back. The third raises a flag that the rest of the chip uses to refuse execution from external memory. The code array is a register array inside the block.

Top module: `flash_prog_ctrl`

## Requirements
- R1: An operation is recognised only while `strap_rst` is 1 and `strap_psen` is 0. In any other case `data_oe` is 0, `data_out` is 0, and no write, lock or erase starts.
- R2: The operation is chosen by `mode_code` = {sel_a, sel_b, sel_c, sel_d}, bit 3 first: 4'b0111 code write, 4'b0011 code read, 4'b1111 lock 1, 4'b1100 lock 2, 4'b1010 lock 3, 4'b1000 chip erase, 4'b0000 signature read. Any other code leaves `data_oe` and `data_out` at 0.
- R3: In code-write mode, a rising edge on `prog_n` starts a write. `ready` is 0 for exactly `WRITE_CYCLES` samples, starting at the first clock edge after the rise. The addressed byte then holds the bitwise AND of its old value and `data_in`.
- R4: While a code write is busy, a code read of the pending address returns, on bit 7, the complement of bit 7 of the value being stored. Once `ready` is back at 1, the read returns the stored byte on all bits.
- R5: A `prog_n` pulse that arrives while `ready` is 0 is ignored. It does not lengthen the busy time and does not change any byte.
- R6: In erase mode, holding `prog_n` low for `ERASE_HOLD` consecutive cycles starts an erase. `ready` is 0 while every byte is set to 8'hFF and all lock bits are cleared. A shorter hold changes nothing.
- R7: A signature read returns 8'h1E at address 0x030 and 8'h51 at 0x031. At 0x032 it returns 8'hFF, or 8'h05 when `LOW_VOLT_PART` is 1. Every other address returns 8'h00.
- R8: After a lock-1 write, a code write does not start: `ready` stays 1 and the byte keeps its value.
- R9: After a lock-2 write, a code read leaves `data_oe` at 0, while signature reads still work.
- R10: After a lock-3 write, `ext_exec_block` is 1 until the next erase.
- R11: During and after reset, with no operation, `ready` is 1 and `data_oe` and `ext_exec_block` are 0.
- R12: `data_out` and `data_oe` are registered. They reflect the mode and address present one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| strap_rst | input | 1 | Reset strap level; must be 1 to program |
| strap_psen | input | 1 | Store-enable strap level; must be 0 to program |
| mode_code | input | 4 | Mode-select pins, bit 3 first as listed in R2 |
| prog_n | input | 1 | Active-low program pulse |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Byte to write |
| data_out | output | DATA_W | Read or signature data |
| data_oe | output | 1 | Data bus driven (0 means high impedance) |
| ready | output | 1 | 1 when idle, 0 while an operation runs |
| ext_exec_block | output | 1 | Lock 3 set: external execution disabled |

## Verification
The bench aims at the write window itself. It reads the pending byte mid-write: a design without polling would return the old 8'hFF there instead of a 0 on bit 7. It also fires a second program pulse into the busy window, which a careless design would accept, corrupting byte 0x200 or stretching the busy count. An erase hold that is too short must leave written data intact, which catches a design that erases on the first edge of `prog_n`. The full erase must also clear every lock, and lock 2 must hide code reads while signature reads keep working.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

   typedef enum logic [2:0] {
      FM_NONE, FM_WRITE, FM_READ, FM_LOCK1, FM_LOCK2, FM_LOCK3, FM_ERASE, FM_SIG
   } fmode_e;

   typedef enum logic [1:0] {
      SQ_IDLE, SQ_CODE, SQ_LOCK, SQ_SWEEP
   } seq_e;

   localparam logic [3:0] PC_WRITE = 4'b0111;
   localparam logic [3:0] PC_READ  = 4'b0011;
   localparam logic [3:0] PC_LOCK1 = 4'b1111;
   localparam logic [3:0] PC_LOCK2 = 4'b1100;
   localparam logic [3:0] PC_LOCK3 = 4'b1010;
   localparam logic [3:0] PC_ERASE = 4'b1000;
   localparam logic [3:0] PC_SIG   = 4'b0000;

   localparam int NUM_LOCKS = 3;

   function automatic fmode_e decode_pins(input logic qual, input logic [3:0] code);
      fmode_e m;
      m = FM_NONE;
      if (qual) begin
         case (code)
            PC_WRITE: m = FM_WRITE;
            PC_READ:  m = FM_READ;
            PC_LOCK1: m = FM_LOCK1;
            PC_LOCK2: m = FM_LOCK2;
            PC_LOCK3: m = FM_LOCK3;
            PC_ERASE: m = FM_ERASE;
            PC_SIG:   m = FM_SIG;
            default:  m = FM_NONE;
         endcase
      end
      return m;
   endfunction

endpackage

// File: rtl/flash_mode_decode.sv
module flash_mode_decode
   import flash_prog_pkg::*;
(
   input  logic       strap_rst,
   input  logic       strap_psen,
   input  logic [3:0] mode_code,
   output fmode_e     mode
);
   logic qual;

   always_comb begin
      qual = strap_rst & ~strap_psen;
      mode = decode_pins(qual, mode_code);
   end
endmodule

// File: rtl/flash_lock_bank.sv
module flash_lock_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         clr_all,
   output logic [N-1:0] lock_q
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          lock_q[g] <= 1'b0;
         else if (clr_all)    lock_q[g] <= 1'b0;
         else if (set_vec[g]) lock_q[g] <= 1'b1;
      end
   end
endmodule

// File: rtl/flash_code_array.sv
module flash_code_array #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
   import flash_prog_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 8,
   parameter int WRITE_CYCLES = 48,
   parameter int ERASE_HOLD   = 96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmode_e            mode,
   input  logic              prog_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] rd_old,
   input  logic              write_locked,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [NUM_LOCKS-1:0] lock_set,
   output logic              lock_clr,
   output logic              pend_valid,
   output logic [ADDR_W-1:0] pend_addr,
   output logic              pend_msb
);
   localparam int MAXC  = (WRITE_CYCLES > ERASE_HOLD) ? WRITE_CYCLES : ERASE_HOLD;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WRITE_CYCLES - 1);
   localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(ERASE_HOLD - 1);
   localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

   seq_e                 state;
   logic [CNT_W-1:0]     cnt;
   logic [CNT_W-1:0]     hold_cnt;
   logic                 prog_q;
   logic                 erase_fired;
   logic [ADDR_W-1:0]    sweep_addr;
   logic [DATA_W-1:0]    pend_data;
   logic [NUM_LOCKS-1:0] lk_sel;
   logic                 rise;
   logic                 hold_ok;
   logic                 timer_done;

   always_comb begin
      rise       = prog_n & ~prog_q;
      hold_ok    = (state == SQ_IDLE) && (mode == FM_ERASE) && !prog_n && !erase_fired;
      timer_done = (cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= SQ_IDLE;
         cnt         <= '0;
         hold_cnt    <= '0;
         prog_q      <= 1'b1;
         erase_fired <= 1'b0;
         sweep_addr  <= '0;
         pend_addr   <= '0;
         pend_data   <= '0;
         lk_sel      <= '0;
      end else begin
         prog_q <= prog_n;
         if (prog_n) erase_fired <= 1'b0;

         if (hold_ok && hold_cnt != HOLD_END) hold_cnt <= hold_cnt + 1'b1;
         else                                 hold_cnt <= '0;

         unique case (state)
            SQ_IDLE: begin
               if (hold_ok && hold_cnt == HOLD_END) begin
                  state       <= SQ_SWEEP;
                  sweep_addr  <= '0;
                  erase_fired <= 1'b1;
               end else if (rise) begin
                  case (mode)
                     FM_WRITE: if (!write_locked) begin
                        state     <= SQ_CODE;
                        cnt       <= WR_LOAD;
                        pend_addr <= addr;
                        pend_data <= rd_old & din;
                     end
                     FM_LOCK1: begin state <= SQ_LOCK; cnt <= WR_LOAD; lk_sel <= 3'b001; end
                     FM_LOCK2: begin state <= SQ_LOCK; cnt <= WR_LOAD; lk_sel <= 3'b010; end
                     FM_LOCK3: begin state <= SQ_LOCK; cnt <= WR_LOAD; lk_sel <= 3'b100; end
                     default: ;
                  endcase
               end
            end
            SQ_CODE, SQ_LOCK: begin
               if (timer_done) state <= SQ_IDLE;
               else            cnt   <= cnt - 1'b1;
            end
            SQ_SWEEP: begin
               if (sweep_addr == LAST_ADDR) state <= SQ_IDLE;
               else                         sweep_addr <= sweep_addr + 1'b1;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      busy       = (state != SQ_IDLE);
      pend_valid = (state == SQ_CODE);
      pend_msb   = pend_data[DATA_W-1];
      mem_we     = 1'b0;
      mem_waddr  = pend_addr;
      mem_wdata  = pend_data;
      lock_set   = '0;
      lock_clr   = 1'b0;
      if (state == SQ_CODE && timer_done) begin
         mem_we = 1'b1;
      end else if (state == SQ_LOCK && timer_done) begin
         lock_set = lk_sel;
      end else if (state == SQ_SWEEP) begin
         mem_we    = 1'b1;
         mem_waddr = sweep_addr;
         mem_wdata = '1;
         lock_clr  = (sweep_addr == LAST_ADDR);
      end
   end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import flash_prog_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter int DATA_W        = 8,
   parameter int OSC_KHZ       = 24000,
   parameter int WRITE_CYCLES  = 48,
   parameter int ERASE_HOLD    = 96,
   parameter int LOW_VOLT_PART = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_rst,
   input  logic              strap_psen,
   input  logic [3:0]        mode_code,
   input  logic              prog_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              ready,
   output logic              ext_exec_block
);
   localparam int WRITE_LIMIT = 2 * OSC_KHZ;
   localparam logic [ADDR_W-1:0] SIG_ID0 = ADDR_W'(12'h030);
   localparam logic [ADDR_W-1:0] SIG_ID1 = ADDR_W'(12'h031);
   localparam logic [ADDR_W-1:0] SIG_ID2 = ADDR_W'(12'h032);

   if (DATA_W != 8) begin : g_bad_width
      $error("flash_prog_ctrl: DATA_W must be 8");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("flash_prog_ctrl: ADDR_W too small for signature addresses");
   end
   if (WRITE_CYCLES < 2 || WRITE_CYCLES > WRITE_LIMIT) begin : g_bad_write
      $error("flash_prog_ctrl: WRITE_CYCLES outside 2..2ms");
   end
   if (ERASE_HOLD < 1) begin : g_bad_hold
      $error("flash_prog_ctrl: ERASE_HOLD must be positive");
   end

   fmode_e               mode;
   logic                 busy;
   logic                 mem_we;
   logic [ADDR_W-1:0]    mem_waddr;
   logic [DATA_W-1:0]    mem_wdata;
   logic [DATA_W-1:0]    rd_data;
   logic [NUM_LOCKS-1:0] lock_set;
   logic                 lock_clr;
   logic [NUM_LOCKS-1:0] lock_q;
   logic                 pend_valid;
   logic [ADDR_W-1:0]    pend_addr;
   logic                 pend_msb;
   logic [7:0]           sig_last;
   logic [7:0]           sig_byte;
   logic [DATA_W-1:0]    read_word;

   flash_mode_decode u_dec (
      .strap_rst (strap_rst),
      .strap_psen(strap_psen),
      .mode_code (mode_code),
      .mode      (mode)
   );

   flash_code_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk  (clk),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(mem_wdata),
      .raddr(addr),
      .rdata(rd_data)
   );

   flash_op_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .WRITE_CYCLES(WRITE_CYCLES), .ERASE_HOLD(ERASE_HOLD)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .prog_n      (prog_n),
      .addr        (addr),
      .din         (data_in),
      .rd_old      (rd_data),
      .write_locked(lock_q[0]),
      .busy        (busy),
      .mem_we      (mem_we),
      .mem_waddr   (mem_waddr),
      .mem_wdata   (mem_wdata),
      .lock_set    (lock_set),
      .lock_clr    (lock_clr),
      .pend_valid  (pend_valid),
      .pend_addr   (pend_addr),
      .pend_msb    (pend_msb)
   );

   flash_lock_bank #(.N(NUM_LOCKS)) u_locks (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(lock_set),
      .clr_all(lock_clr),
      .lock_q (lock_q)
   );

   if (LOW_VOLT_PART != 0) begin : g_sig_lv
      assign sig_last = 8'h05;
   end else begin : g_sig_hv
      assign sig_last = 8'hFF;
   end

   always_comb begin
      if      (addr == SIG_ID0) sig_byte = 8'h1E;
      else if (addr == SIG_ID1) sig_byte = 8'h51;
      else if (addr == SIG_ID2) sig_byte = sig_last;
      else                      sig_byte = 8'h00;

      read_word = rd_data;
      if (pend_valid && pend_addr == addr) read_word[DATA_W-1] = ~pend_msb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_oe  <= 1'b0;
         data_out <= '0;
      end else begin
         data_oe  <= 1'b0;
         data_out <= '0;
         if (mode == FM_READ && !lock_q[1]) begin
            data_oe  <= 1'b1;
            data_out <= read_word;
         end else if (mode == FM_SIG) begin
            data_oe  <= 1'b1;
            data_out <= DATA_W'(sig_byte);
         end
      end
   end

   assign ready          = ~busy;
   assign ext_exec_block = lock_q[2];
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk
   import flash_prog_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_rst,
   input logic              strap_psen,
   input logic [3:0]        mode_code,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] data_out,
   input logic              data_oe,
   input logic              ready,
   input logic              ext_exec_block,
   input logic [2:0]        lock_q
);
   logic seen = 1'b0;
   logic qual;
   logic known;

   always_ff @(posedge clk) seen <= 1'b1;

   always_comb begin
      qual  = strap_rst & ~strap_psen;
      known = (mode_code == PC_WRITE) || (mode_code == PC_READ) ||
              (mode_code == PC_LOCK1) || (mode_code == PC_LOCK2) ||
              (mode_code == PC_LOCK3) || (mode_code == PC_ERASE) ||
              (mode_code == PC_SIG);
   end

   // R1
   a_r1_unqualified_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $past(!qual) |-> !data_oe && data_out == '0);

   // R2
   a_r2_unknown_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $past(!known) |-> !data_oe);

   // R7
   a_r7_sig_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $past(rst_n && qual && mode_code == PC_SIG && addr == ADDR_W'(12'h030))
      |-> data_oe && data_out == DATA_W'(8'h1E));

   // R9
   a_r9_read_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $past(lock_q[1] && mode_code == PC_READ) |-> !data_oe);

   // R6
   a_r6_flag_clears_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $fell(ext_exec_block) |-> !$past(ready));

   // R3
   a_r3_busy_spans_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $fell(ready) |=> !ready);
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .strap_rst     (strap_rst),
   .strap_psen    (strap_psen),
   .mode_code     (mode_code),
   .addr          (addr),
   .data_out      (data_out),
   .data_oe       (data_oe),
   .ready         (ready),
   .ext_exec_block(ext_exec_block),
   .lock_q        (lock_q)
);

// File: tb/flash_prog_ctrl_bench.sv
`timescale 1ns/1ps
module flash_prog_ctrl_bench;
   localparam int AW = 12;
   localparam int DW = 8;
   localparam int WC = 48;
   localparam int EH = 96;

   localparam logic [3:0] C_WRITE = 4'b0111;
   localparam logic [3:0] C_READ  = 4'b0011;
   localparam logic [3:0] C_LK1   = 4'b1111;
   localparam logic [3:0] C_LK2   = 4'b1100;
   localparam logic [3:0] C_LK3   = 4'b1010;
   localparam logic [3:0] C_ERASE = 4'b1000;
   localparam logic [3:0] C_SIG   = 4'b0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strap_rst = 1'b0;
   logic          strap_psen = 1'b1;
   logic [3:0]    mode_code = 4'b0101;
   logic          prog_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data_in = '0;
   logic [DW-1:0] data_out;
   logic          data_oe;
   logic          ready;
   logic          ext_exec_block;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int          due;
      logic        oe;
      logic [7:0]  data;
      logic [7:0]  mask;
      string       tag;
   } exp_t;
   exp_t sb[$];

   flash_prog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WC), .ERASE_HOLD(EH))
   u_flash_prog_ctrl (
      .clk(clk), .rst_n(rst_n), .strap_rst(strap_rst), .strap_psen(strap_psen),
      .mode_code(mode_code), .prog_n(prog_n), .addr(addr), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe), .ready(ready),
      .ext_exec_block(ext_exec_block)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc++;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard entries due in this cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         check(e.due == cyc && data_oe == e.oe && ((data_out & e.mask) == (e.data & e.mask)),
               e.tag, {data_oe, data_out}, {e.oe, e.data & e.mask});
      end
   end

   // driver: present mode/address, expect registered result one edge later (R12)
   task automatic expect_read(input logic [3:0] code, input logic [AW-1:0] a,
                              input logic oe, input logic [7:0] d, input logic [7:0] m,
                              input string tag);
      mode_code = code;
      addr      = a;
      sb.push_back('{cyc + 1, oe, d, m, tag});
      @(negedge clk);
   endtask

   task automatic wait_ready(input int limit);
      for (int i = 0; i < limit && !ready; i++) @(negedge clk);
      check(ready == 1'b1, "ready timeout", ready, 1);
   endtask

   task automatic pulse(input logic [3:0] code, input logic [AW-1:0] a, input logic [7:0] d);
      mode_code = code; addr = a; data_in = d; prog_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      prog_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic erase(input int hold);
      mode_code = C_ERASE; prog_n = 1'b0;
      repeat (hold) @(negedge clk);
      prog_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      int k;
      int m;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(ready == 1 && data_oe == 0 && ext_exec_block == 0, "R11 reset state",
            {ready, data_oe, ext_exec_block}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1 && data_oe == 0, "R11 idle after reset", {ready, data_oe}, 2'b10);

      // R1 strap not qualified: no drive
      expect_read(C_READ, 12'h030, 1'b0, 8'h00, 8'hFF, "R1 straps unqualified");
      strap_rst = 1'b1;
      expect_read(C_SIG, 12'h030, 1'b0, 8'h00, 8'hFF, "R1 psen strap high");
      strap_psen = 1'b0;

      // R6 full erase
      erase(EH + 4);
      check(ready == 1'b0, "R6 erase busy", ready, 0);
      wait_ready(6000);
      expect_read(C_READ, 12'h000, 1'b1, 8'hFF, 8'hFF, "R6 erased low");
      expect_read(C_READ, 12'h123, 1'b1, 8'hFF, 8'hFF, "R6 erased mid");
      expect_read(C_READ, 12'hFFF, 1'b1, 8'hFF, 8'hFF, "R12 R6 erased top");

      // R3 timed write, R4 polling, R5 ignored pulse
      mode_code = C_WRITE; addr = 12'h123; data_in = 8'hA5; prog_n = 1'b0;
      @(negedge clk); @(negedge clk);
      prog_n = 1'b1;
      k = cyc;
      @(negedge clk);
      check(ready == 1'b0, "R3 busy after rise", ready, 0);
      expect_read(C_READ, 12'h123, 1'b1, 8'h00, 8'h80, "R4 poll bit7");
      mode_code = C_WRITE; addr = 12'h200; data_in = 8'h00; prog_n = 1'b0;
      @(negedge clk); @(negedge clk);
      prog_n = 1'b1;
      @(negedge clk);
      expect_read(C_READ, 12'h123, 1'b1, 8'h00, 8'h80, "R4 poll bit7 again");
      while (!ready && cyc - k < 500) @(negedge clk);
      m = cyc;
      check(m - k - 1 == WC, "R3 R5 busy length", m - k - 1, WC);
      expect_read(C_READ, 12'h123, 1'b1, 8'hA5, 8'hFF, "R4 true data");
      expect_read(C_READ, 12'h200, 1'b1, 8'hFF, 8'hFF, "R5 ignored pulse");

      // R3 AND merge
      pulse(C_WRITE, 12'h123, 8'h3C);
      wait_ready(200);
      expect_read(C_READ, 12'h123, 1'b1, 8'h24, 8'hFF, "R3 and merge");

      // R6 short hold does nothing
      erase(EH / 4);
      check(ready == 1'b1, "R6 short hold idle", ready, 1);
      expect_read(C_READ, 12'h123, 1'b1, 8'h24, 8'hFF, "R6 short hold kept data");

      // R2 undefined code
      expect_read(4'b0101, 12'h123, 1'b0, 8'h00, 8'hFF, "R2 undefined code");
      expect_read(4'b1110, 12'h030, 1'b0, 8'h00, 8'hFF, "R2 undefined code b");

      // R7 signature
      expect_read(C_SIG, 12'h030, 1'b1, 8'h1E, 8'hFF, "R7 sig 030");
      expect_read(C_SIG, 12'h031, 1'b1, 8'h51, 8'hFF, "R7 sig 031");
      expect_read(C_SIG, 12'h032, 1'b1, 8'hFF, 8'hFF, "R7 sig 032");
      expect_read(C_SIG, 12'h033, 1'b1, 8'h00, 8'hFF, "R7 sig other");

      // R8 lock 1
      pulse(C_LK1, 12'h000, 8'h00);
      wait_ready(200);
      pulse(C_WRITE, 12'h124, 8'h00);
      check(ready == 1'b1, "R8 write refused", ready, 1);
      expect_read(C_READ, 12'h124, 1'b1, 8'hFF, 8'hFF, "R8 byte unchanged");

      // R9 lock 2
      pulse(C_LK2, 12'h000, 8'h00);
      wait_ready(200);
      expect_read(C_READ, 12'h123, 1'b0, 8'h00, 8'hFF, "R9 read hidden");
      expect_read(C_SIG, 12'h031, 1'b1, 8'h51, 8'hFF, "R9 sig still read");

      // R10 lock 3
      check(ext_exec_block == 1'b0, "R10 flag before lock", ext_exec_block, 0);
      pulse(C_LK3, 12'h000, 8'h00);
      wait_ready(200);
      check(ext_exec_block == 1'b1, "R10 flag set", ext_exec_block, 1);

      // R6 erase clears locks
      erase(EH + 2);
      wait_ready(6000);
      check(ext_exec_block == 1'b0, "R6 lock 3 cleared", ext_exec_block, 0);
      expect_read(C_READ, 12'h123, 1'b1, 8'hFF, 8'hFF, "R6 read back after erase");
      pulse(C_WRITE, 12'h124, 8'h5A);
      wait_ready(200);
      expect_read(C_READ, 12'h124, 1'b1, 8'h5A, 8'hFF, "R6 lock 1 cleared");

      @(negedge clk);
      check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(150000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule